// File: doc/BRIEF.md
# Debug Trigger Match Comparator

This block decides whether a memory or instruction-fetch access should fire one of four hardware debug triggers. Each trigger holds a configuration word and a compare value. For every access, the block filters each trigger by operation kind and by privilege level. It then compares the access address or the access data against the trigger's compare value, using one of six compare modes. Finally it resolves chained groups and reports the lowest-index trigger that fires, together with that trigger's action code.

The surrounding core presents one access per strobe. It gets back a registered result one cycle later: a valid flag, a hit flag, the index of the firing trigger and its action field. While the hart runs in debug mode, nothing fires. A 32-bit mode input truncates the compared value to its low 32 bits and halves the split point used by the two half-word mask modes.

Top module: `trig_match_top`

## Requirements
- R1: Triggers are scanned from index 0 upward. The reported index is the lowest trigger that fires, and an access with no firing trigger gives hit_o = 0.
- R2: A trigger takes part only if its enable bit for the operation is set. op_i encodes execute = 0, load = 1 and store = 2. Code 3 never matches.
- R3: A trigger takes part only if its enable bit for the privilege level is set. priv_i encodes U = 0, S = 1, H = 2 and M = 3.
- R4: When the trigger's sel_data bit is set, data_i is compared. When it is clear, addr_i is compared.
- R5: With narrow_i = 1, the compared value is cut to its low 32 bits before the compare.
- R6: Mode code 0 requires the value to be exactly equal to the compare value. Codes 6 and 7 never match.
- R7: Mode code 1 (NAPOT) ignores as many low bits as the compare value has trailing ones, and compares the remaining bits.
- R8: Mode code 2 fires when value >= compare value, and mode code 3 fires when value < compare value. Both compares are unsigned.
- R9: Let h be half the width (XLEN/2, or 16 with narrow_i set), and let mask = compare value >> h. Mode code 4 fires when (value & mask) == (compare value & mask). Mode code 5 fires when ((value >> h) & mask) == (compare value & mask).
- R10: When dbg_mode_i = 1, no trigger fires.
- R11: A trigger that matches with its chain bit set does not report by itself. A group fires only when every member matches, and the hit is reported at the group's first member whose chain bit is clear, with that member's action.
- R12: When a chained member does not match, the triggers after it are skipped, up to and including the next trigger whose chain bit is clear. Scanning then resumes normally.
- R13: valid_o, hit_o, hit_idx_o and hit_action_o change one cycle after a valid_i strobe. hit_o is 0 whenever valid_o is 0, and both are 0 after reset.

Within cfg_i, trigger i occupies bits [i*15 +: 15]. From MSB to LSB the fields are: sel_data, action[2:0], chain, mode[2:0], en_m, en_h, en_s, en_u, en_exec, en_load, en_store. Within cmpval_i, trigger i's compare value occupies bits [i*XLEN +: XLEN].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Access strobe |
| op_i | input | 2 | Operation kind |
| priv_i | input | 2 | Current privilege level |
| addr_i | input | XLEN | Access address |
| data_i | input | XLEN | Access data |
| dbg_mode_i | input | 1 | Hart is in debug mode |
| narrow_i | input | 1 | 32-bit register width in effect |
| cfg_i | input | NUM_TRIG*15 | Per-trigger configuration words |
| cmpval_i | input | NUM_TRIG*XLEN | Per-trigger compare values |
| valid_o | output | 1 | Result valid |
| hit_o | output | 1 | A trigger fired |
| hit_idx_o | output | $clog2(NUM_TRIG) | Index of the firing trigger |
| hit_action_o | output | 3 | Action field of the firing trigger |

## Verification
The only state in this block is the output register and the chain-scan flag, which is re-evaluated for every access. A wrong scan state therefore shows up in the very next result, never later. A chain flag that wrongly stays clear or set shows as a hit reported at the wrong index, or as a hit that should have been suppressed, on the cycle after the strobe. A mask or mode decode fault shows as a hit flag of the wrong polarity for an address placed just inside or just outside the boundary. Each compare mode is probed on both sides of its boundary.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;

    localparam int MODE_EQ     = 0;
    localparam int MODE_NAPOT  = 1;
    localparam int MODE_GE     = 2;
    localparam int MODE_LT     = 3;
    localparam int MODE_MASKLO = 4;
    localparam int MODE_MASKHI = 5;

    typedef enum logic [1:0] {
        OP_EXEC  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_H = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    typedef struct packed {
        logic       sel_data;
        logic [2:0] action;
        logic       chain;
        logic [2:0] mode;
        logic       en_m;
        logic       en_h;
        logic       en_s;
        logic       en_u;
        logic       en_exec;
        logic       en_load;
        logic       en_store;
    } trig_cfg_t;

    localparam int CFG_W = $bits(trig_cfg_t);

    function automatic logic op_enabled(trig_cfg_t c, logic [1:0] op);
        case (op)
            OP_EXEC:  return c.en_exec;
            OP_LOAD:  return c.en_load;
            OP_STORE: return c.en_store;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic priv_enabled(trig_cfg_t c, logic [1:0] priv);
        case (priv)
            PRIV_U:  return c.en_u;
            PRIV_S:  return c.en_s;
            PRIV_H:  return c.en_h;
            default: return c.en_m;
        endcase
    endfunction

endpackage

// File: rtl/trig_match_unit.sv
module trig_match_unit
    import trig_match_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  trig_cfg_t         cfg,
    input  logic [XLEN-1:0]   cmpval,
    input  logic [XLEN-1:0]   addr,
    input  logic [XLEN-1:0]   data,
    input  logic [1:0]        op,
    input  logic [1:0]        priv,
    input  logic              narrow,
    output logic              match
);
    localparam int HALF_W   = XLEN / 2;
    localparam int SHIFT_W  = $clog2(XLEN);

    logic [XLEN-1:0]    value;
    logic [XLEN-1:0]    ones_run;
    logic [XLEN-1:0]    napot_mask;
    logic [SHIFT_W-1:0] half_sh;
    logic [XLEN-1:0]    half_mask;
    logic [XLEN-1:0]    value_hi;
    logic               qualified;
    logic               cmp_ok;

    always_comb begin
        value = cfg.sel_data ? data : addr;
        if (narrow) value = value & XLEN'(33'h0_FFFF_FFFF);
    end

    // Bit k of ones_run is set when bits 0..k of the compare value are all ones.
    always_comb begin
        ones_run[0] = cmpval[0];
        for (int k = 1; k < XLEN; k++) ones_run[k] = ones_run[k-1] & cmpval[k];
        napot_mask = ~ones_run;
    end

    always_comb begin
        half_sh   = narrow ? SHIFT_W'(16) : SHIFT_W'(HALF_W);
        half_mask = cmpval >> half_sh;
        value_hi  = value >> half_sh;
    end

    always_comb begin
        case (int'(cfg.mode))
            MODE_EQ:     cmp_ok = (value == cmpval);
            MODE_NAPOT:  cmp_ok = ((value & napot_mask) == (cmpval & napot_mask));
            MODE_GE:     cmp_ok = (value >= cmpval);
            MODE_LT:     cmp_ok = (value < cmpval);
            MODE_MASKLO: cmp_ok = ((value & half_mask) == (cmpval & half_mask));
            MODE_MASKHI: cmp_ok = ((value_hi & half_mask) == (cmpval & half_mask));
            default:     cmp_ok = 1'b0;
        endcase
    end

    assign qualified = op_enabled(cfg, op) && priv_enabled(cfg, priv);
    assign match     = qualified && cmp_ok;

endmodule

// File: rtl/trig_chain_resolve.sv
module trig_chain_resolve #(
    parameter int NUM_TRIG = 4,
    localparam int IDX_W   = $clog2(NUM_TRIG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TRIG-1:0] match,
    input  logic [NUM_TRIG-1:0] chain,
    output logic                hit,
    output logic [IDX_W-1:0]    idx
);
    logic ok;

    always_comb begin
        ok  = 1'b1;
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (!hit) begin
                if (!ok) begin
                    if (!chain[i]) ok = 1'b1;
                end else if (match[i]) begin
                    if (!chain[i]) begin
                        hit = 1'b1;
                        idx = IDX_W'(i);
                    end
                end else if (chain[i]) begin
                    ok = 1'b0;
                end
            end
        end
    end

    // R11
    group_end_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (!chain[idx] && match[idx]));

endmodule

// File: rtl/trig_out_reg.sv
module trig_out_reg #(
    parameter int NUM_TRIG = 4,
    localparam int IDX_W   = $clog2(NUM_TRIG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_in,
    input  logic             hit_in,
    input  logic [IDX_W-1:0] idx_in,
    input  logic [2:0]       action_in,
    output logic             valid_out,
    output logic             hit_out,
    output logic [IDX_W-1:0] idx_out,
    output logic [2:0]       action_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out  <= 1'b0;
            hit_out    <= 1'b0;
            idx_out    <= '0;
            action_out <= '0;
        end else begin
            valid_out <= valid_in;
            hit_out   <= valid_in && hit_in;
            if (valid_in) begin
                idx_out    <= hit_in ? idx_in : '0;
                action_out <= hit_in ? action_in : 3'd0;
            end
        end
    end

    // R13
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        hit_out |-> valid_out);

endmodule

// File: rtl/trig_match_top.sv
module trig_match_top
    import trig_match_pkg::*;
#(
    parameter int NUM_TRIG = 4,
    parameter int XLEN     = 64,
    localparam int IDX_W   = $clog2(NUM_TRIG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     valid_i,
    input  logic [1:0]               op_i,
    input  logic [1:0]               priv_i,
    input  logic [XLEN-1:0]          addr_i,
    input  logic [XLEN-1:0]          data_i,
    input  logic                     dbg_mode_i,
    input  logic                     narrow_i,
    input  logic [NUM_TRIG*CFG_W-1:0] cfg_i,
    input  logic [NUM_TRIG*XLEN-1:0] cmpval_i,
    output logic                     valid_o,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         hit_idx_o,
    output logic [2:0]               hit_action_o
);
    trig_cfg_t           cfg_a [NUM_TRIG];
    logic [NUM_TRIG-1:0] raw_match;
    logic [NUM_TRIG-1:0] live_match;
    logic [NUM_TRIG-1:0] chain_v;
    logic                comb_hit;
    logic [IDX_W-1:0]    comb_idx;
    logic [2:0]          comb_action;

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
        assign cfg_a[g]   = trig_cfg_t'(cfg_i[g*CFG_W +: CFG_W]);
        assign chain_v[g] = cfg_a[g].chain;

        trig_match_unit #(.XLEN(XLEN)) unit_i (
            .cfg    (cfg_a[g]),
            .cmpval (cmpval_i[g*XLEN +: XLEN]),
            .addr   (addr_i),
            .data   (data_i),
            .op     (op_i),
            .priv   (priv_i),
            .narrow (narrow_i),
            .match  (raw_match[g])
        );
    end

    assign live_match = dbg_mode_i ? '0 : raw_match;

    trig_chain_resolve #(.NUM_TRIG(NUM_TRIG)) resolve_i (
        .clk   (clk),
        .rst   (rst),
        .match (live_match),
        .chain (chain_v),
        .hit   (comb_hit),
        .idx   (comb_idx)
    );

    assign comb_action = cfg_a[comb_idx].action;

    trig_out_reg #(.NUM_TRIG(NUM_TRIG)) out_i (
        .clk        (clk),
        .rst        (rst),
        .valid_in   (valid_i),
        .hit_in     (comb_hit),
        .idx_in     (comb_idx),
        .action_in  (comb_action),
        .valid_out  (valid_o),
        .hit_out    (hit_o),
        .idx_out    (hit_idx_o),
        .action_out (hit_action_o)
    );

    // R13
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!valid_o && !hit_o));

    // R10
    dbg_block_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && dbg_mode_i) |=> !hit_o);

endmodule

// File: tb/trig_match_top_tb_top.sv
`timescale 1ns/1ps
module trig_match_top_tb_top;
    import trig_match_pkg::*;

    localparam int NT = 4;
    localparam int XW = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             valid_i = 1'b0;
    logic [1:0]       op_i = 2'd0;
    logic [1:0]       priv_i = 2'd3;
    logic [XW-1:0]    addr_i = '0;
    logic [XW-1:0]    data_i = '0;
    logic             dbg_mode_i = 1'b0;
    logic             narrow_i = 1'b0;
    logic [NT*CFG_W-1:0] cfg_bus;
    logic [NT*XW-1:0] cmp_bus;
    logic             valid_o, hit_o;
    logic [1:0]       hit_idx_o;
    logic [2:0]       hit_action_o;

    trig_cfg_t        cfgs [NT];
    logic [XW-1:0]    cmps [NT];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [5:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            cfg_bus[i*CFG_W +: CFG_W] = cfgs[i];
            cmp_bus[i*XW +: XW]       = cmps[i];
        end
    end

    trig_match_top #(.NUM_TRIG(NT), .XLEN(XW)) dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .priv_i(priv_i),
        .addr_i(addr_i), .data_i(data_i), .dbg_mode_i(dbg_mode_i),
        .narrow_i(narrow_i), .cfg_i(cfg_bus), .cmpval_i(cmp_bus),
        .valid_o(valid_o), .hit_o(hit_o), .hit_idx_o(hit_idx_o),
        .hit_action_o(hit_action_o)
    );

    // privm = {m,h,s,u}, opm = {exec,load,store}
    function automatic trig_cfg_t mk(logic sel, logic [2:0] act, logic ch,
                                     logic [2:0] mode, logic [3:0] privm, logic [2:0] opm);
        trig_cfg_t c;
        c.sel_data = sel; c.action = act; c.chain = ch; c.mode = mode;
        {c.en_m, c.en_h, c.en_s, c.en_u} = privm;
        {c.en_exec, c.en_load, c.en_store} = opm;
        return c;
    endfunction

    task automatic clear_cfg();
        for (int i = 0; i < NT; i++) begin
            cfgs[i] = '0;
            cmps[i] = '0;
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [1:0] pv,
                        input logic [XW-1:0] a, input logic [XW-1:0] d,
                        input logic dbg, input logic nar,
                        input logic eh, input logic [1:0] ei, input logic [2:0] ea,
                        input string tag);
        @(negedge clk);
        op_i = op; priv_i = pv; addr_i = a; data_i = d;
        dbg_mode_i = dbg; narrow_i = nar; valid_i = 1'b1;
        exp_q.push_back({eh, ei, ea});
        tag_q.push_back(tag);
        @(posedge clk);
        #1 valid_i = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R13: unexpected valid_o actual=1 expected=0");
            end else begin
                logic [5:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (hit_o !== e[5] || (e[5] && (hit_idx_o !== e[4:3] || hit_action_o !== e[2:0]))) begin
                    fails++;
                    $display("FAIL %s: actual hit=%0d idx=%0d act=%0d expected hit=%0d idx=%0d act=%0d",
                             t, hit_o, hit_idx_o, hit_action_o, e[5], e[4:3], e[2:0]);
                end
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        clear_cfg();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (valid_o !== 1'b0 || hit_o !== 1'b0) begin
            fails++;
            $display("FAIL R13 reset: actual valid=%0d hit=%0d expected 0 0", valid_o, hit_o);
        end

        // R1: lowest index among qualifying triggers; no hit otherwise
        clear_cfg();
        cfgs[1] = mk(0, 3'd2, 0, 3'd0, 4'hF, 3'b100); cmps[1] = 64'h1000;
        cfgs[2] = mk(0, 3'd6, 0, 3'd0, 4'hF, 3'b100); cmps[2] = 64'h1000;
        send(OP_EXEC, PRIV_M, 64'h1000, 0, 0, 0, 1, 2'd1, 3'd2, "R1 lowest");
        send(OP_EXEC, PRIV_M, 64'h1004, 0, 0, 0, 0, 2'd0, 3'd0, "R1 none");

        // R2: operation filter
        clear_cfg();
        cfgs[0] = mk(0, 3'd1, 0, 3'd0, 4'hF, 3'b010); cmps[0] = 64'h2000;
        send(OP_EXEC,  PRIV_M, 64'h2000, 0, 0, 0, 0, 2'd0, 3'd0, "R2 exec off");
        send(OP_LOAD,  PRIV_M, 64'h2000, 0, 0, 0, 1, 2'd0, 3'd1, "R2 load on");
        send(OP_STORE, PRIV_M, 64'h2000, 0, 0, 0, 0, 2'd0, 3'd0, "R2 store off");
        send(OP_NONE,  PRIV_M, 64'h2000, 0, 0, 0, 0, 2'd0, 3'd0, "R2 code3");

        // R3: privilege filter, U only
        clear_cfg();
        cfgs[0] = mk(0, 3'd3, 0, 3'd0, 4'b0001, 3'b100); cmps[0] = 64'h3000;
        send(OP_EXEC, PRIV_M, 64'h3000, 0, 0, 0, 0, 2'd0, 3'd0, "R3 M off");
        send(OP_EXEC, PRIV_U, 64'h3000, 0, 0, 0, 1, 2'd0, 3'd3, "R3 U on");

        // R4: data select
        clear_cfg();
        cfgs[0] = mk(1, 3'd4, 0, 3'd0, 4'hF, 3'b001); cmps[0] = 64'hABCD;
        send(OP_STORE, PRIV_M, 64'hABCD, 64'h0, 0, 0, 0, 2'd0, 3'd0, "R4 addr ignored");
        send(OP_STORE, PRIV_M, 64'h0, 64'hABCD, 0, 0, 1, 2'd0, 3'd4, "R4 data used");

        // R5: 32-bit truncation
        clear_cfg();
        cfgs[0] = mk(0, 3'd1, 0, 3'd0, 4'hF, 3'b100); cmps[0] = 64'h1234_5678;
        send(OP_EXEC, PRIV_M, 64'hFFFF_FFFF_1234_5678, 0, 0, 0, 0, 2'd0, 3'd0, "R5 wide");
        send(OP_EXEC, PRIV_M, 64'hFFFF_FFFF_1234_5678, 0, 0, 1, 1, 2'd0, 3'd1, "R5 narrow");

        // R6: unknown mode codes
        clear_cfg();
        cfgs[0] = mk(0, 3'd1, 0, 3'd6, 4'hF, 3'b100); cmps[0] = 64'h500;
        send(OP_EXEC, PRIV_M, 64'h500, 0, 0, 0, 0, 2'd0, 3'd0, "R6 code6");
        cfgs[0].mode = 3'd7;
        send(OP_EXEC, PRIV_M, 64'h500, 0, 0, 0, 0, 2'd0, 3'd0, "R6 code7");

        // R7: NAPOT, three trailing ones
        clear_cfg();
        cfgs[0] = mk(0, 3'd2, 0, 3'd1, 4'hF, 3'b100); cmps[0] = 64'h1007;
        send(OP_EXEC, PRIV_M, 64'h1005, 0, 0, 0, 1, 2'd0, 3'd2, "R7 inside");
        send(OP_EXEC, PRIV_M, 64'h1008, 0, 0, 0, 0, 2'd0, 3'd0, "R7 outside");

        // R8: GE / LT unsigned
        clear_cfg();
        cfgs[0] = mk(0, 3'd5, 0, 3'd2, 4'hF, 3'b100); cmps[0] = 64'h100;
        send(OP_EXEC, PRIV_M, 64'h100, 0, 0, 0, 1, 2'd0, 3'd5, "R8 ge eq");
        send(OP_EXEC, PRIV_M, 64'hFF,  0, 0, 0, 0, 2'd0, 3'd0, "R8 ge below");
        send(OP_EXEC, PRIV_M, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 1, 2'd0, 3'd5, "R8 ge unsigned");
        cfgs[0].mode = 3'd3;
        send(OP_EXEC, PRIV_M, 64'hFF,  0, 0, 0, 1, 2'd0, 3'd5, "R8 lt below");
        send(OP_EXEC, PRIV_M, 64'h100, 0, 0, 0, 0, 2'd0, 3'd0, "R8 lt eq");

        // R9: half-word mask modes
        clear_cfg();
        cfgs[0] = mk(0, 3'd6, 0, 3'd4, 4'hF, 3'b010); cmps[0] = 64'h0000_FF00_0000_1200;
        send(OP_LOAD, PRIV_M, 64'h12AB, 0, 0, 0, 1, 2'd0, 3'd6, "R9 masklo hit");
        send(OP_LOAD, PRIV_M, 64'h1300, 0, 0, 0, 0, 2'd0, 3'd0, "R9 masklo miss");
        cfgs[0].mode = 3'd5;
        send(OP_LOAD, PRIV_M, 64'h0000_12CD_0000_0000, 0, 0, 0, 1, 2'd0, 3'd6, "R9 maskhi hit");
        send(OP_LOAD, PRIV_M, 64'h0000_1300_0000_0000, 0, 0, 0, 0, 2'd0, 3'd0, "R9 maskhi miss");

        // R10: debug mode suppression
        clear_cfg();
        cfgs[0] = mk(0, 3'd1, 0, 3'd0, 4'hF, 3'b100); cmps[0] = 64'h700;
        send(OP_EXEC, PRIV_M, 64'h700, 0, 1, 0, 0, 2'd0, 3'd0, "R10 dbg");
        send(OP_EXEC, PRIV_M, 64'h700, 0, 0, 0, 1, 2'd0, 3'd1, "R10 normal");

        // R11: chained pair
        clear_cfg();
        cfgs[0] = mk(0, 3'd1, 1, 3'd0, 4'hF, 3'b001); cmps[0] = 64'h40;
        cfgs[1] = mk(1, 3'd5, 0, 3'd0, 4'hF, 3'b001); cmps[1] = 64'h55;
        send(OP_STORE, PRIV_M, 64'h40, 64'h55, 0, 0, 1, 2'd1, 3'd5, "R11 group hit");
        send(OP_STORE, PRIV_M, 64'h40, 64'h00, 0, 0, 0, 2'd0, 3'd0, "R11 partial");

        // R12: broken chain skips its tail
        clear_cfg();
        cfgs[0] = mk(0, 3'd1, 1, 3'd0, 4'hF, 3'b100); cmps[0] = 64'h40;
        cfgs[1] = mk(0, 3'd3, 0, 3'd2, 4'hF, 3'b100); cmps[1] = 64'h0;
        cfgs[2] = mk(0, 3'd7, 0, 3'd0, 4'hF, 3'b100); cmps[2] = 64'h80;
        send(OP_EXEC, PRIV_M, 64'h80, 0, 0, 0, 1, 2'd2, 3'd7, "R12 tail skipped");
        send(OP_EXEC, PRIV_M, 64'h40, 0, 0, 0, 1, 2'd1, 3'd3, "R12 chain whole");

        // R13: idle cycles give no result
        repeat (3) @(negedge clk);
        checks++;
        if (valid_o !== 1'b0 || hit_o !== 1'b0 || exp_q.size() != 0) begin
            fails++;
            $display("FAIL R13 idle: actual valid=%0d hit=%0d pending=%0d expected 0 0 0",
                     valid_o, hit_o, exp_q.size());
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule